// File: doc/BRIEF.md
# MDIO management master

This block carries out one register access at a time to an Ethernet PHY over the two-wire management bus. A host presents a request for one cycle: a start pulse, a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs the whole bus transaction by itself. It drives the management clock, a serial data output and an output enable for the shared data line. During reads it samples the returned data input.

Every access begins with a full preamble of 32 clock pulses with the line held high. The address frame follows. A write then sends a driven turnaround and the data word. A read lets go of the line without a clock edge and gives one turnaround pulse. It then checks whether the PHY pulled the line low, and shifts in 16 data bits. If a PHY leaves the line high at the acknowledge point, the read reports an error and returns zero. Each clock phase lasts `PHASE_CYC` system-clock cycles, and `PHASE_CYC` may be as small as 1.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is running, mdc is low, mdo is high, mdoEn is high, busy and done are low, and err and rdData are 0.
- R2: A transaction starts with 32 bit slots in which mdo is high and mdoEn is high.
- R3: After the preamble the block sends, MSB first, the start code 01, then the operation code (read 10, write 01), then the 5-bit PHY address, then the 5-bit register address.
- R4: Each bit slot has three phases, each PHASE_CYC cycles long: mdc low with the data set, then mdc high, then mdc low. A transaction has 64 bit slots.
- R5: In a write, the register address is followed by the turnaround code 10 and then the 16 write-data bits, MSB first, with mdoEn high throughout.
- R6: In a read, mdoEn falls at the start of slot 46 while mdc is low and has also been low in the cycle before. It stays low through slot 63, which covers the turnaround pulse and the read portion.
- R7: In a read, mdi is sampled at the end of the first (low) phase of slot 47. If it is high, err is 1 and rdData is 0, whatever data follows.
- R8: In a read, slots 48 to 63 each sample mdi at the end of their low phase, just before the rising edge. The sampled bits form rdData, MSB first.
- R9: After slot 63 comes one phase with mdc low, mdoEn high and mdo high. Then done is high for exactly one cycle, and busy falls in that same cycle. busy is high from the cycle after the accepted start until then.
- R10: A start pulse while busy is high is ignored. The running transaction and its latched fields are not disturbed.
- R11: err and rdData change only in the done cycle. A write sets err to 0 and leaves rdData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request pulse |
| rdReq | input | 1 | 1 = read, 0 = write, sampled with start |
| phyAddr | input | 5 | PHY address, sampled with start |
| regAddr | input | 5 | Register address, sampled with start |
| wrData | input | 16 | Write data, sampled with start |
| rdData | output | 16 | Data returned by the last read |
| err | output | 1 | Last read saw no acknowledge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data out |
| mdoEn | output | 1 | Output enable for the data line |
| mdi | input | 1 | Serial data in |

## Verification
The bench aims at the read turnaround. It checks that mdoEn drops with no mdc edge around it. A design that released the line one phase late would collide with the PHY, and one that released it early would corrupt the last register-address bit. It also checks a missing acknowledge where the PHY still drives a non-zero data pattern. A design that failed to mask the data would return that pattern instead of zero. A start pulse injected in the middle of a transaction, with different fields, is there to catch a design that restarts or relatches. Addresses at 0 and 31 and data words with a single bit set expose errors in bit order and field alignment.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int CODE_W     = 2;
  // header = start code + op code + PHY address + register address
  localparam int HDR_BITS   = 2 * CODE_W + 2 * ADDR_W;
  localparam int TAIL_BITS  = CODE_W + DATA_W;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TAIL_BITS;
  localparam int REL_SLOT   = PRE_BITS + HDR_BITS;   // read releases the line here
  localparam int ACK_SLOT   = REL_SLOT + 1;          // acknowledge sample
  localparam int DATA_SLOT  = REL_SLOT + CODE_W;     // first read data sample

  localparam logic [CODE_W-1:0] CODE_START = 2'b01;
  localparam logic [CODE_W-1:0] CODE_RD    = 2'b10;
  localparam logic [CODE_W-1:0] CODE_WR    = 2'b01;
  localparam logic [CODE_W-1:0] CODE_WTA   = 2'b10;

  typedef struct packed {
    logic load;
    logic shift;
    logic ackSample;
    logic dataSample;
    logic finish;
  } dpCtl_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   rdReq,
  output logic   busy,
  output logic   done,
  output logic   mdc,
  output logic   lineFree,
  output dpCtl_t ctl
);
  localparam int DIV_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int SLOT_W = $clog2(FRAME_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);
  localparam logic [SLOT_W-1:0] REL_IDX   = SLOT_W'(REL_SLOT);
  localparam logic [SLOT_W-1:0] ACK_IDX   = SLOT_W'(ACK_SLOT);
  localparam logic [SLOT_W-1:0] DATA_IDX  = SLOT_W'(DATA_SLOT);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t state;
  logic [1:0] step;
  logic [SLOT_W-1:0] slot;
  logic isRead;
  logic mdcQ;
  logic relQ;
  logic doneQ;
  logic tick;
  logic divClr;

  assign divClr = (state == S_IDLE);

  generate
    if (PHASE_CYC == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [DIV_W-1:0] LAST = DIV_W'(PHASE_CYC - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst || divClr || divCnt == LAST) divCnt <= '0;
        else                                 divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      step   <= 2'd0;
      slot   <= '0;
      isRead <= 1'b0;
      mdcQ   <= 1'b0;
      relQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_RUN;
            step   <= 2'd0;
            slot   <= '0;
            isRead <= rdReq;
            mdcQ   <= 1'b0;
            relQ   <= 1'b0;
          end
        end
        S_RUN: begin
          if (tick) begin
            case (step)
              2'd0: begin
                step <= 2'd1;
                mdcQ <= 1'b1;
              end
              2'd1: begin
                step <= 2'd2;
                mdcQ <= 1'b0;
              end
              default: begin
                step <= 2'd0;
                if (slot == LAST_SLOT) begin
                  state <= S_FIN;
                  relQ  <= 1'b0;
                end else begin
                  slot <= slot + 1'b1;
                  relQ <= isRead && ((slot + 1'b1) >= REL_IDX);
                end
              end
            endcase
          end
        end
        default: begin
          if (tick) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = (state == S_IDLE) && start;
    ctl.shift      = (state == S_RUN) && tick && (step == 2'd2);
    ctl.ackSample  = (state == S_RUN) && tick && (step == 2'd0) && isRead && (slot == ACK_IDX);
    ctl.dataSample = (state == S_RUN) && tick && (step == 2'd0) && isRead && (slot >= DATA_IDX);
    ctl.finish     = (state == S_FIN) && tick;
  end

  assign busy     = (state != S_IDLE);
  assign done     = doneQ;
  assign mdc      = mdcQ;
  assign lineFree = relQ;
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdi,
  output logic              mdo,
  output logic [DATA_W-1:0] rdData,
  output logic              err
);
  logic [FRAME_BITS-1:0] txSh;
  logic [DATA_W-1:0]     rxSh;
  logic                  rdLat;
  logic                  noAck;
  logic [DATA_W-1:0]     rdQ;
  logic                  errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      txSh  <= '1;
      rxSh  <= '0;
      rdLat <= 1'b0;
      noAck <= 1'b0;
      rdQ   <= '0;
      errQ  <= 1'b0;
    end else begin
      if (ctl.load) begin
        rdLat <= rdReq;
        noAck <= 1'b0;
        if (rdReq)
          txSh <= {{PRE_BITS{1'b1}}, CODE_START, CODE_RD, phyAddr, regAddr, {TAIL_BITS{1'b1}}};
        else
          txSh <= {{PRE_BITS{1'b1}}, CODE_START, CODE_WR, phyAddr, regAddr, CODE_WTA, wrData};
      end else if (ctl.shift) begin
        txSh <= {txSh[FRAME_BITS-2:0], 1'b1};
      end
      if (ctl.ackSample)  noAck <= mdi;
      if (ctl.dataSample) rxSh  <= {rxSh[DATA_W-2:0], mdi};
      if (ctl.finish) begin
        if (rdLat) begin
          errQ <= noAck;
          rdQ  <= noAck ? '0 : rxSh;
        end else begin
          errQ <= 1'b0;
        end
      end
    end
  end

  assign mdo    = txSh[FRAME_BITS-1];
  assign rdData = rdQ;
  assign err    = errQ;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rdReq,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        err,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdo,
  output logic        mdoEn,
  input  logic        mdi
);
  dpCtl_t ctl;
  logic   lineFree;

  mdio_ctrl #(.PHASE_CYC(PHASE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rdReq(rdReq),
    .busy(busy), .done(done), .mdc(mdc), .lineFree(lineFree), .ctl(ctl)
  );

  mdio_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rdReq(rdReq),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .mdi(mdi),
    .mdo(mdo), .rdData(rdData), .err(err)
  );

  assign mdoEn = !lineFree;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mdc,
  input logic        mdo,
  input logic        mdoEn,
  input logic [15:0] rdData
);
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && mdo && mdoEn));

  p_release_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mdoEn) |-> (!mdc && !$past(mdc)));

  p_release_in_txn_r6: assert property (@(posedge clk) disable iff (rst)
    !mdoEn |-> busy);

  p_reclaim_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mdoEn) |-> !mdc);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_busy_begin_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdData == 16'h0000));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(err) && $stable(rdData)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
  .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn), .rdData(rdData)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int P = 2;
  localparam int TXN_EDGES = (64 * 3 + 1) * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rdReq = 1'b0;
  logic [4:0] phyAddr = '0;
  logic [4:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic mdi = 1'b1;
  logic [15:0] rdData;
  logic err, busy, done, mdc, mdo, mdoEn;

  mdio_master #(.PHASE_CYC(P)) dut (
    .clk(clk), .rst(rst), .start(start), .rdReq(rdReq), .phyAddr(phyAddr),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .err(err), .busy(busy),
    .done(done), .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn), .mdi(mdi)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChk = 0;
  int nFail = 0;
  int wd = 0;

  // PHY behaviour chosen by each test
  bit phyNoAck = 0;
  logic [15:0] phyWord = '0;

  // reference model state
  bit mBusy = 0, mDone = 0, mOp = 0, mErr = 0;
  int mN = 0;
  logic [15:0] mRd = '0;
  bit frm[64];
  int fp;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic addField(input int val, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      frm[fp] = val[i];
      fp++;
    end
  endtask

  // model: advances on the edge, reads only the bench's own request inputs
  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mDone = 0; mN = 0; mErr = 0; mRd = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mN++;
        if (mN == TXN_EDGES) begin
          mBusy = 0;
          mDone = 1;
          if (mOp) begin
            mErr = phyNoAck;
            mRd  = phyNoAck ? 16'h0 : phyWord;
          end else begin
            mErr = 0;
          end
        end
      end else if (start) begin
        mBusy = 1; mN = 0; mOp = rdReq; fp = 0;
        for (int i = 0; i < 32; i++) addField(1, 1);
        addField(1, 2);
        addField(rdReq ? 2 : 1, 2);
        addField(int'(phyAddr), 5);
        addField(int'(regAddr), 5);
        if (rdReq) addField(32'h3FFFF, 18);
        else begin
          addField(2, 2);
          addField(int'(wrData), 16);
        end
      end
    end
  end

  // per-cycle comparison and PHY drive, away from the active edge
  int ph, sl, st;
  bit eMdc, eOe, eMdo;
  string mdoTag;
  always @(negedge clk) begin
    if (!rst) begin
      eMdc = 0; eOe = 1; eMdo = 1; mdoTag = "R1"; sl = -1;
      if (mBusy) begin
        ph = mN / P;
        if (ph < 192) begin
          sl = ph / 3; st = ph % 3;
          eMdc = (st == 1);
          eOe  = !(mOp && sl >= 46);
          eMdo = frm[sl];
          mdoTag = (sl < 32) ? "R2" : (sl < 46) ? "R3" : "R5";
        end else mdoTag = "R9";
      end
      check(mdc === eMdc, "R4", "mdc", mdc, eMdc);
      check(mdoEn === eOe, "R6", "mdoEn", mdoEn, eOe);
      if (eOe) check(mdo === eMdo, mdoTag, "mdo", mdo, eMdo);
      check(busy === mBusy, "R9", "busy", busy, mBusy);
      check(done === mDone, "R9", "done", done, mDone);
      check(err === mErr, "R7", "err", err, mErr);
      check(rdData === mRd, "R8", "rdData", rdData, mRd);
      // PHY: line pulled up except where it answers a read
      if (mBusy && mOp && sl == 47)      mdi <= phyNoAck;
      else if (mBusy && mOp && sl >= 48) mdi <= phyWord[63 - sl];
      else                               mdi <= 1'b1;
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic launch(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] d);
    @(negedge clk); #2;
    start = 1; rdReq = rd; phyAddr = pa; regAddr = ra; wrData = d;
    @(negedge clk); #2;
    start = 0;
  endtask

  task automatic waitDone();
    while (done !== 1'b1) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R1: reset state
    check(!mdc && mdo && mdoEn && !busy && !done && !err && rdData == 0,
          "R1", "idle bus/status", {mdc, mdo, mdoEn, busy, done, err}, 6'b011000);

    // R2 R3 R4 R5: write frame
    launch(0, 5'h11, 5'h05, 16'hBEEF);
    waitDone();
    check(err == 0, "R11", "err after write", err, 0);

    // R8: normal read, PHY at the top address
    phyNoAck = 0; phyWord = 16'hA5C3;
    launch(1, 5'd31, 5'd0, 16'h0);
    waitDone();
    check(rdData == 16'hA5C3 && err == 0, "R8", "read word", rdData, 16'hA5C3);

    // R7: no acknowledge, PHY still drives a pattern: result must be zero
    phyNoAck = 1; phyWord = 16'h7E81;
    launch(1, 5'd3, 5'd17, 16'h0);
    waitDone();
    check(err == 1, "R7", "err flag", err, 1);
    check(rdData == 16'h0, "R7", "masked data", rdData, 0);

    // R11: write clears err, leaves rdData
    phyNoAck = 0;
    launch(0, 5'd0, 5'd31, 16'h8001);
    waitDone();
    check(err == 0, "R11", "err cleared by write", err, 0);
    check(rdData == 16'h0, "R11", "rdData kept", rdData, 0);

    // R10: start pulse with other fields while busy is ignored
    phyWord = 16'h0001;
    launch(1, 5'h0A, 5'h15, 16'h0);
    repeat (60) @(negedge clk);
    #2; start = 1; rdReq = 0; phyAddr = 5'h1F; regAddr = 5'h1F; wrData = 16'hFFFF;
    @(negedge clk); #2; start = 0;
    check(busy == 1, "R10", "still busy after ignored start", busy, 1);
    waitDone();
    check(rdData == 16'h0001 && err == 0, "R10", "original read kept", rdData, 16'h0001);

    // R8: single MSB, address edges
    phyWord = 16'h8000;
    launch(1, 5'd0, 5'd31, 16'h0);
    waitDone();
    check(rdData == 16'h8000, "R8", "MSB first", rdData, 16'h8000);

    // R9: a new request accepted right after done
    launch(0, 5'd1, 5'd2, 16'h1234);
    waitDone();
    check(busy == 0, "R9", "busy low at done", busy, 0);

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule